// File: doc/BRIEF.md
# One-Time-Programmable Security Register Program Engine

This block models, on the device side, the write path into three small one-time-programmable security registers of a serial flash device. Each register holds 256 bytes. A host reaches them over a single-bit SPI slave link (chip select, serial clock, serial data in). The SPI pins are sampled with the block's own system clock. The engine recognises a program command, captures a 24-bit address and gathers the data bytes that follow. When chip select is released, it merges the gathered bytes into the selected register.

The write is guarded three ways. A write-enable latch must be set first by a separate one-byte enable command. The address must name one of the three registers. The register's lock input must be low. Programming can only turn ones into zeros, as in a real erased cell. A read port exposes any byte of any register, so the stored contents can be inspected.

Top module: `otp_secreg_prog`

## Requirements
- R1: A program frame is the byte 0x42, then a 24-bit address, then data bytes. Each byte is shifted in most significant bit first on rising serial-clock edges while `cs_n` is low. Data byte k lands at byte offset (address[7:0] + k) of the selected register.
- R2: One frame may carry 1 to 256 data bytes. The byte offset wraps from 0xFF to 0x00 inside the same register.
- R3: A program frame changes nothing unless `wel_o` is 1 when `cs_n` rises.
- R4: Address bits [15:12] select the register (1, 2 or 3). The frame is ignored, with `wel_o` unchanged, if the select is any other value, if bits [23:16] are nonzero, or if bits [11:8] are nonzero.
- R5: A programmed byte becomes old AND data, so no stored bit ever goes from 0 to 1.
- R6: `lock_i[0]`, `lock_i[1]` and `lock_i[2]` protect registers 1, 2 and 3. A frame aimed at a register whose lock bit is 1 is ignored, with `wel_o` unchanged.
- R7: Data is committed only if `cs_n` rises after a whole number of bytes and at least one complete data byte. Otherwise the whole frame is discarded and `wel_o` is kept.
- R8: A committed program frame clears `wel_o`.
- R9: The byte 0x06 sets `wel_o` only when `cs_n` rises after exactly 8 bits. A frame of any other bit length leaves `wel_o` unchanged.
- R10: Frames work with the serial clock idling low (mode 0) and idling high (mode 3).
- R11: After reset, `wel_o` is 0 and every byte of every register reads 0xFF. Reading with `rd_sel` outside 1..3 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock |
| mosi | input | 1 | SPI serial data into the device |
| lock_i | input | 3 | Per-register lock bits; bit 0 protects register 1 |
| rd_sel | input | 2 | Register number to read (1..3) |
| rd_addr | input | 8 | Byte offset to read |
| rd_data | output | 8 | Stored byte at the read location |
| wel_o | output | 1 | Write-enable latch |

## Verification
Two situations are hard to reach from the ports. One is a frame whose contents are fully valid but which must still be thrown away, because it ends a few bits past a byte boundary. The other is a write that runs past offset 0xFF. The stimulus reaches both by building frames bit by bit: a valid address and data followed by a short tail of bits, and a program starting at 0xFE that carries four bytes or a full 256 bytes. Ignored frames are confirmed by reading back the offsets they would have written and by checking that the write-enable latch is still set.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int REG_COUNT  = 3;
    localparam int REG_DEPTH  = 256;
    localparam int BYTE_W     = 8;
    localparam int OFF_W      = $clog2(REG_DEPTH);
    localparam int IDX_W      = $clog2(REG_COUNT + 1);
    localparam int BIT_IDX_W  = $clog2(BYTE_W);
    localparam int HDR_BYTES  = 4;

    localparam logic [BYTE_W-1:0] OP_PROG = 8'h42;
    localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
    localparam logic [BYTE_W-1:0] ERASED  = 8'hFF;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic [7:0] hi;
        logic [3:0] sel;
        logic [3:0] mid;
        logic [7:0] off;
    } addr_t;

    typedef enum logic [2:0] {
        PH_OP   = 3'd0,
        PH_A2   = 3'd1,
        PH_A1   = 3'd2,
        PH_A0   = 3'd3,
        PH_DATA = 3'd4
    } phase_e;

    function automatic logic addr_valid(input addr_t a);
        return (a.hi == 8'h00) && (a.mid == 4'h0) &&
               (a.sel >= 4'd1) && (a.sel <= 4'(REG_COUNT));
    endfunction

    function automatic logic [1:0] sel_to_idx(input logic [3:0] sel);
        return 2'(sel - 4'd1);
    endfunction
endpackage

// File: rtl/otp_spi_sync.sv
module otp_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic bit_stb,
    output logic bit_val,
    output logic frame_start,
    output logic frame_end
);
    logic [STAGES-1:0] ck_s, cs_s, di_s;
    logic ck_prev, cs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_s    <= '0;
            cs_s    <= '1;
            di_s    <= '0;
            ck_prev <= 1'b0;
            cs_prev <= 1'b1;
        end else begin
            ck_s    <= {ck_s[STAGES-2:0], sclk};
            cs_s    <= {cs_s[STAGES-2:0], cs_n};
            di_s    <= {di_s[STAGES-2:0], mosi};
            ck_prev <= ck_s[STAGES-1];
            cs_prev <= cs_s[STAGES-1];
        end
    end

    assign bit_stb     = ck_s[STAGES-1] & ~ck_prev & ~cs_s[STAGES-1];
    assign bit_val     = di_s[STAGES-1];
    assign frame_start = ~cs_s[STAGES-1] & cs_prev;
    assign frame_end   = cs_s[STAGES-1] & ~cs_prev;
endmodule

// File: rtl/otp_cmd_deframer.sv
module otp_cmd_deframer
    import otp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_stb,
    input  logic                 bit_val,
    input  logic                 frame_start,
    output byte_t                opcode,
    output addr_t                addr,
    output logic [BIT_IDX_W-1:0] bit_idx,
    output phase_e               phase,
    output logic                 data_seen,
    output logic                 data_stb,
    output byte_t                data_byte,
    output logic [OFF_W-1:0]     data_ptr
);
    byte_t             shreg;
    byte_t             nxt;
    logic [23:0]       addr_q;
    logic [OFF_W-1:0]  ptr_q;
    logic              byte_done;

    assign nxt       = {shreg[BYTE_W-2:0], bit_val};
    assign byte_done = bit_stb && (bit_idx == BIT_IDX_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            shreg     <= '0;
            bit_idx   <= '0;
            phase     <= PH_OP;
            data_seen <= 1'b0;
            opcode    <= '0;
            addr_q    <= '0;
            ptr_q     <= '0;
        end else if (bit_stb) begin
            shreg   <= nxt;
            bit_idx <= bit_idx + 1'b1;
            if (byte_done) begin
                unique case (phase)
                    PH_OP: begin
                        opcode <= nxt;
                        phase  <= PH_A2;
                    end
                    PH_A2: begin
                        addr_q[23:16] <= nxt;
                        phase         <= PH_A1;
                    end
                    PH_A1: begin
                        addr_q[15:8] <= nxt;
                        phase        <= PH_A0;
                    end
                    PH_A0: begin
                        addr_q[7:0] <= nxt;
                        ptr_q       <= OFF_W'(nxt);
                        phase       <= PH_DATA;
                    end
                    default: begin
                        data_seen <= 1'b1;
                        ptr_q     <= ptr_q + 1'b1;
                    end
                endcase
            end
        end
    end

    assign addr      = addr_t'(addr_q);
    assign data_stb  = byte_done && (phase == PH_DATA);
    assign data_byte = nxt;
    assign data_ptr  = ptr_q;
endmodule

// File: rtl/otp_stage_buf.sv
module otp_stage_buf
    import otp_pkg::*;
#(
    parameter int DEPTH = REG_DEPTH,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic                        wr_en,
    input  logic [PW-1:0]               wr_ptr,
    input  byte_t                       wr_byte,
    output logic [DEPTH-1:0][BYTE_W-1:0] stg_data,
    output logic [DEPTH-1:0]            stg_vld
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                stg_vld[i]  <= 1'b0;
                stg_data[i] <= ERASED;
            end else if (wr_en && (wr_ptr == PW'(i))) begin
                stg_vld[i]  <= 1'b1;
                stg_data[i] <= wr_byte;
            end
        end
    end
endmodule

// File: rtl/otp_secreg_bank.sv
module otp_secreg_bank
    import otp_pkg::*;
#(
    parameter int REGS  = REG_COUNT,
    parameter int DEPTH = REG_DEPTH,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit,
    input  logic [1:0]                   commit_idx,
    input  logic [DEPTH-1:0][BYTE_W-1:0] stg_data,
    input  logic [DEPTH-1:0]             stg_vld,
    input  logic [1:0]                   rd_sel,
    input  logic [PW-1:0]                rd_addr,
    output byte_t                        rd_data
);
    byte_t      rd_r [REGS];
    logic [1:0] rd_idx;

    for (genvar r = 0; r < REGS; r++) begin : g_reg
        byte_t mem [DEPTH];
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= ERASED;
                end else if (commit && (commit_idx == 2'(r)) && stg_vld[i]) begin
                    mem[i] <= mem[i] & stg_data[i];
                end
            end
        end
        assign rd_r[r] = mem[rd_addr];
    end

    assign rd_idx = rd_sel - 2'd1;

    always_comb begin
        rd_data = ERASED;
        if ((rd_sel != 2'd0) && (32'(rd_sel) <= REGS)) begin
            rd_data = rd_r[rd_idx];
        end
    end
endmodule

// File: rtl/otp_secreg_prog.sv
module otp_secreg_prog
    import otp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic [2:0] lock_i,
    input  logic [1:0] rd_sel,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       wel_o
);
    logic                         bit_stb, bit_val, frame_start, frame_end;
    byte_t                        opcode;
    addr_t                        addr;
    logic [BIT_IDX_W-1:0]         bit_idx;
    phase_e                       phase;
    logic                         data_seen, data_stb;
    byte_t                        data_byte;
    logic [OFF_W-1:0]             data_ptr;
    logic [REG_DEPTH-1:0][BYTE_W-1:0] stg_data;
    logic [REG_DEPTH-1:0]         stg_vld;
    logic [1:0]                   tgt_idx;
    logic                         on_boundary, prog_ok, commit, wren_hit, wel_q;

    otp_spi_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .bit_stb(bit_stb), .bit_val(bit_val),
        .frame_start(frame_start), .frame_end(frame_end)
    );

    otp_cmd_deframer deframe_i (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
        .frame_start(frame_start), .opcode(opcode), .addr(addr),
        .bit_idx(bit_idx), .phase(phase), .data_seen(data_seen),
        .data_stb(data_stb), .data_byte(data_byte), .data_ptr(data_ptr)
    );

    otp_stage_buf #(.DEPTH(REG_DEPTH)) stage_i (
        .clk(clk), .rst(rst), .clear(frame_start), .wr_en(data_stb),
        .wr_ptr(data_ptr), .wr_byte(data_byte),
        .stg_data(stg_data), .stg_vld(stg_vld)
    );

    assign tgt_idx     = sel_to_idx(addr.sel);
    assign on_boundary = (bit_idx == '0);
    assign prog_ok     = (opcode == OP_PROG) && data_seen && on_boundary &&
                         addr_valid(addr) && !lock_i[tgt_idx];
    assign commit      = frame_end && prog_ok && wel_q;
    assign wren_hit    = frame_end && (opcode == OP_WREN) &&
                         (phase == PH_A2) && on_boundary;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q <= 1'b0;
        end else if (commit) begin
            wel_q <= 1'b0;
        end else if (wren_hit) begin
            wel_q <= 1'b1;
        end
    end

    otp_secreg_bank #(.REGS(REG_COUNT), .DEPTH(REG_DEPTH)) bank_i (
        .clk(clk), .rst(rst), .commit(commit), .commit_idx(tgt_idx),
        .stg_data(stg_data), .stg_vld(stg_vld),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign wel_o = wel_q;
endmodule

// File: rtl/otp_secreg_prog_chk.sv
module otp_secreg_prog_chk
    import otp_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 commit,
    input logic                 wren_hit,
    input logic                 wel_o,
    input logic                 frame_end,
    input logic [BIT_IDX_W-1:0] bit_idx,
    input addr_t                addr,
    input logic [2:0]           lock_i,
    input logic [1:0]           rd_sel,
    input logic [7:0]           rd_addr,
    input logic [7:0]           rd_data
);
    assert_commit_needs_wel_R3: assert property (@(posedge clk) disable iff (rst)
        commit |-> wel_o);

    assert_commit_addr_ok_R4: assert property (@(posedge clk) disable iff (rst)
        commit |-> (addr.hi == 8'h00 && addr.mid == 4'h0 &&
                    addr.sel != 4'd0 && addr.sel < 4'd4));

    assert_commit_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
        commit |-> !lock_i[addr.sel[1:0] - 2'd1]);

    assert_commit_whole_bytes_R7: assert property (@(posedge clk) disable iff (rst)
        commit |-> (frame_end && bit_idx == '0));

    assert_wel_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        commit |=> !wel_o);

    assert_wel_set_R9: assert property (@(posedge clk) disable iff (rst)
        wren_hit && !commit |=> wel_o);

    assert_bits_only_fall_R5: assert property (@(posedge clk) disable iff (rst)
        ($stable(rd_sel) && $stable(rd_addr)) |-> ((rd_data & ~$past(rd_data)) == 8'h00));
endmodule

bind otp_secreg_prog otp_secreg_prog_chk chk_i (
    .clk(clk), .rst(rst), .commit(commit), .wren_hit(wren_hit),
    .wel_o(wel_o), .frame_end(frame_end), .bit_idx(bit_idx), .addr(addr),
    .lock_i(lock_i), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/otp_secreg_prog_tb_top.sv
`timescale 1ns/1ps
module otp_secreg_prog_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic [2:0] lock_i = 3'b000;
    logic [1:0] rd_sel = 2'd1;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       wel_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mon_busy = 0;

    localparam int HALF = 20;

    typedef struct {
        bit    is_wel;
        int    sel;
        int    addr;
        int    exp;
        string req;
    } item_t;
    item_t sb_q[$];

    int mem_m [3][256];
    bit wel_m;

    always #2.5 clk = ~clk;

    otp_secreg_prog dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .lock_i(lock_i), .rd_sel(rd_sel), .rd_addr(rd_addr),
        .rd_data(rd_data), .wel_o(wel_o)
    );

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        item_t it;
        int act;
        forever begin
            wait (sb_q.size() > 0);
            mon_busy = 1;
            it = sb_q.pop_front();
            @(negedge clk);
            if (!it.is_wel) begin
                rd_sel  = 2'(it.sel);
                rd_addr = 8'(it.addr);
            end
            @(negedge clk);
            act = it.is_wel ? int'(wel_o) : int'(rd_data);
            checks++;
            if (act !== it.exp) begin
                errors++;
                if (it.is_wel)
                    $display("FAIL %s: wel_o actual %0d expected %0d", it.req, act, it.exp);
                else
                    $display("FAIL %s: reg%0d[%02h] actual %02h expected %02h",
                             it.req, it.sel, it.addr, act, it.exp);
            end
            mon_busy = 0;
        end
    end

    task automatic push_mem(int sel, int a, string req);
        item_t it;
        it.is_wel = 0; it.sel = sel; it.addr = a & 255;
        it.exp = (sel >= 1 && sel <= 3) ? mem_m[sel-1][a & 255] : 255;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic push_wel(string req);
        item_t it;
        it.is_wel = 1; it.sel = 0; it.addr = 0; it.exp = int'(wel_m); it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    task automatic spi_bits(bit bits[$], bit m3);
        sclk = m3;
        #(HALF);
        cs_n = 1'b0;
        #(HALF);
        foreach (bits[i]) begin
            sclk = 1'b0;
            mosi = bits[i];
            #(HALF);
            sclk = 1'b1;
            #(HALF);
        end
        if (!m3) sclk = 1'b0;
        #(HALF);
        cs_n = 1'b1;
        #(4 * HALF);
    endtask

    task automatic add_byte(ref bit bits[$], input logic [7:0] b);
        for (int k = 7; k >= 0; k--) bits.push_back(b[k]);
    endtask

    task automatic wren(bit m3, int extra, string req);
        bit bits[$];
        add_byte(bits, 8'h06);
        for (int k = 0; k < extra; k++) bits.push_back(1'b0);
        spi_bits(bits, m3);
        if (extra == 0) wel_m = 1;
        push_wel(req);
        drain();
    endtask

    task automatic prog(logic [23:0] a, logic [7:0] d[$], int tail, bit m3, string req);
        bit bits[$];
        int sel;
        bit ok;
        int stg [256];
        bit vld [256];
        add_byte(bits, 8'h42);
        add_byte(bits, a[23:16]);
        add_byte(bits, a[15:8]);
        add_byte(bits, a[7:0]);
        foreach (d[i]) add_byte(bits, d[i]);
        for (int k = 0; k < tail; k++) bits.push_back(1'b0);
        spi_bits(bits, m3);
        sel = int'(a[15:12]);
        ok = wel_m && a[23:16] == 8'h00 && a[11:8] == 4'h0 &&
             sel >= 1 && sel <= 3 && d.size() >= 1 && tail == 0;
        if (ok) ok = !lock_i[sel-1];
        for (int i = 0; i < 256; i++) vld[i] = 0;
        foreach (d[i]) begin
            stg[(int'(a[7:0]) + i) & 255] = int'(d[i]);
            vld[(int'(a[7:0]) + i) & 255] = 1;
        end
        if (ok) begin
            for (int i = 0; i < 256; i++)
                if (vld[i]) mem_m[sel-1][i] = mem_m[sel-1][i] & stg[i];
            wel_m = 0;
        end
        if (sel < 1 || sel > 3) sel = 1;
        for (int i = 0; i < 256; i++) if (vld[i]) push_mem(sel, i, req);
        push_mem(sel, (int'(a[7:0]) + d.size()) & 255, req);
        push_wel(req);
        drain();
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d[$];
        for (int r = 0; r < 3; r++) for (int i = 0; i < 256; i++) mem_m[r][i] = 255;
        wel_m = 0;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (3) @(posedge clk);

        // R11 reset state and out-of-range read select
        push_wel("R11");
        push_mem(1, 0, "R11"); push_mem(2, 8'h80, "R11"); push_mem(3, 8'hFF, "R11");
        push_mem(0, 5, "R11");
        drain();

        // R3 no write-enable: ignored
        d = '{8'h00, 8'h11};
        prog(24'h001020, d, 0, 0, "R3");

        // R9 enable with wrong lengths, then exact 8 bits
        wren(0, 1, "R9");
        wren(0, 8, "R9");
        wren(0, 0, "R9");

        // R1 R8 basic program, mode 0
        d = '{8'hA5, 8'h3C, 8'h00};
        prog(24'h001010, d, 0, 0, "R1_R8");

        // R2 R10 wrap, mode 3
        wren(1, 0, "R10");
        d = '{8'h12, 8'h34, 8'h56, 8'h78};
        prog(24'h0020FE, d, 0, 1, "R2_R10");

        // R5 AND merge over existing data
        wren(0, 0, "R5");
        d = '{8'hF0, 8'hFF};
        prog(24'h001010, d, 0, 0, "R5");

        // R4 invalid addresses ignored, latch kept
        wren(0, 0, "R4");
        d = '{8'h00};
        prog(24'h004030, d, 0, 0, "R4");
        prog(24'h000030, d, 0, 0, "R4");
        prog(24'h010030, d, 0, 1, "R4");
        prog(24'h001130, d, 0, 0, "R4");

        // R6 lock on register 3 ignored, register 1 still works
        lock_i = 3'b100;
        prog(24'h003040, d, 0, 0, "R6");
        d = '{8'h0F};
        prog(24'h001040, d, 0, 0, "R6");
        lock_i = 3'b000;

        // R7 trailing partial byte and header-only frame discarded
        wren(1, 0, "R7");
        d = '{8'h00, 8'h00};
        prog(24'h002050, d, 3, 1, "R7");
        d.delete();
        prog(24'h002050, d, 0, 0, "R7");

        // R2 full 256-byte frame into register 3
        d.delete();
        for (int i = 0; i < 256; i++) d.push_back(8'(i ^ 8'h5A));
        prog(24'h003080, d, 0, 0, "R2");
        wren(0, 0, "R2");
        prog(24'h003080, d, 0, 0, "R2");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule